// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Alarm

This block keeps the time of day and the calendar date as packed BCD fields: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A sub-second pulse train drives it. A small divider turns those pulses into one-second advances. The advance ripples up through the fields in the same clock cycle, and each field follows its own limit. The month limit follows the calendar and includes a leap-year February. Hours count in either 24-hour or 12-hour form, and a mode input selects the form.

Software loads any field through a byte-wide write port. A stop input freezes time keeping. On release the sub-second divider restarts from half a second, so the first advance comes half a second after time keeping resumes. An alarm unit compares up to four fields against alarm registers, and each alarm register has its own enable. The alarm sets a sticky flag on the first cycle in which all enabled fields agree. Software clears the flag with an AND-style write.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the outputs read 00 seconds, 00 minutes, hour 0x00, weekday 0, day 0x01, month 0x01, year 0x00 and a clear alarm flag. All alarm fields reset to disabled.
- R2: With stop low, every SUB_DIV-th `sub_tick` pulse (default 2) advances the seconds by one. Seconds roll from 0x59 to 0x00 and carry into the minutes, and minutes roll from 0x59 to 0x00 and carry into the hours.
- R3: With `mode_12h` low, hours run 0x00 to 0x23 and then wrap to 0x00, carrying one day forward.
- R4: With `mode_12h` high, hour bits 4:0 hold BCD 1 to 12 and bit 5 is the PM marker (1 = PM). The count 11 goes to 12 and toggles the marker, and 12 goes to 1. A day carry happens only when 11 PM wraps to 12 AM (0x31 to 0x12).
- R5: Day of month wraps to 0x01 after 0x31 in January, March, May, July, August, October and December, after 0x30 in April, June, September and November, and after 0x28 in February, or after 0x29 when the binary year value is a multiple of four. Month wraps 0x12 to 0x01 and carries into the year, and the year wraps 0x99 to 0x00. The weekday counts 0 to 6 and wraps to 0 on every day carry.
- R6: While `stop` is high no field advances. Once `stop` falls, the first advance comes on the SUB_DIV/2-th `sub_tick` pulse (half a second).
- R7: A write with `wr_en` high loads `wr_data` into the register at `wr_addr`: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year, 8 alarm minutes, 9 alarm hours, 10 alarm day, 11 alarm weekday, 12 flag register. A write beats an advance in the same cycle. Writes to addresses 7, 13, 14 and 15 change nothing.
- R8: A non-BCD value is counted forward without being trapped. A low digit of 9 or above becomes 0 and the high digit is incremented, so 0x3C in seconds becomes 0x40.
- R9: In each alarm register, bit 7 = 1 enables the field. The compared bits are minutes 6:0, hours 5:0 (including the PM marker), day 5:0 and weekday 2:0. The flag goes high one cycle after the first cycle in which all enabled fields match. With no field enabled it never sets.
- R10: A match that lasts does not set the flag again: once cleared, the flag stays low until the match has gone away and returned.
- R11: A write to the flag register ANDs bit 0 into the flag, so 1 keeps it and 0 clears it. When a new match and a clearing write fall in the same cycle, the flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_tick | input | 1 | One-cycle pulse, SUB_DIV per second |
| stop | input | 1 | Freezes time keeping, re-arms half-second phase |
| mode_12h | input | 1 | 1 = 12-hour format, 0 = 24-hour |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select |
| wr_data | input | 8 | Write data |
| sec_o | output | 7 | Seconds, BCD |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 6 | Hours, BCD (bit 5 = PM in 12-hour mode) |
| wday_o | output | 3 | Weekday 0..6 |
| day_o | output | 6 | Day of month, BCD |
| month_o | output | 5 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| alarm_flag_o | output | 1 | Sticky alarm flag |

## Verification
Assertions check on every cycle the following: every time field holds its value when there is no advance and no write, seconds and months land on their wrap values, and the PM marker toggles on the 11 to 12 step. They also check that advances never fall on two cycles in a row, that the flag rises only after a rising match, and that it cannot come back without one. The calendar's month lengths, the leap-year rule, the half-second release phase, the write-versus-advance priority and the set-beats-clear case depend on chosen register contents. Only the bench's directed scenarios can show those.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_SEC   = 4'd0;
  localparam logic [ADDR_W-1:0] A_MIN   = 4'd1;
  localparam logic [ADDR_W-1:0] A_HOUR  = 4'd2;
  localparam logic [ADDR_W-1:0] A_WDAY  = 4'd3;
  localparam logic [ADDR_W-1:0] A_DAY   = 4'd4;
  localparam logic [ADDR_W-1:0] A_MON   = 4'd5;
  localparam logic [ADDR_W-1:0] A_YEAR  = 4'd6;
  localparam logic [ADDR_W-1:0] A_AMIN  = 4'd8;
  localparam logic [ADDR_W-1:0] A_AHOUR = 4'd9;
  localparam logic [ADDR_W-1:0] A_ADAY  = 4'd10;
  localparam logic [ADDR_W-1:0] A_AWDAY = 4'd11;
  localparam logic [ADDR_W-1:0] A_FLAG  = 4'd12;

  // Next BCD value; a low digit at or past 9 rolls into the high digit.
  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    logic [3:0] hi;
    logic [3:0] lo;
    if (v[3:0] >= 4'd9) begin
      hi = v[7:4] + 4'd1;
      lo = 4'd0;
    end else begin
      hi = v[7:4];
      lo = v[3:0] + 4'd1;
    end
    return {hi, lo};
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
    return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
  endfunction

  function automatic logic is_leap(input logic [7:0] yr_bcd);
    logic [7:0] b;
    b = bcd_to_bin(yr_bcd);
    return (b[1:0] == 2'b00);
  endfunction

  // Last valid day (BCD) of a month for a given year.
  function automatic logic [5:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
    logic [5:0] r;
    case (mon)
      5'h02:                      r = is_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default:                    r = 6'h31;
    endcase
    return r;
  endfunction

  // 12-hour step: {pm, hh}. 11 -> 12 flips pm, 12 -> 1 keeps it.
  function automatic logic [5:0] step_12h(input logic [5:0] h);
    logic [7:0] t;
    logic [5:0] r;
    t = bcd_step({3'b000, h[4:0]});
    if (h[4:0] == 5'h12)      r = {h[5], 5'h01};
    else if (h[4:0] == 5'h11) r = {~h[5], 5'h12};
    else                      r = {h[5], t[4:0]};
    return r;
  endfunction
endpackage

// File: rtl/cal_tick_gate.sv
module cal_tick_gate #(
  parameter int SUB_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sub_tick,
  input  logic stop,
  output logic sec_adv
);
  localparam int CW = $clog2(SUB_DIV + 1);
  localparam logic [CW-1:0] FULL = CW'(SUB_DIV);
  localparam logic [CW-1:0] HALF = CW'(SUB_DIV / 2);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] left_q;

  assign sec_adv = sub_tick && !stop && (left_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)        left_q <= FULL;
    else if (stop)     left_q <= HALF;
    else if (sub_tick) left_q <= (left_q == ONE) ? FULL : left_q - ONE;
  end

  // R6
  adv_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_adv |=> !sec_adv);
endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_adv,
  input  logic              mode_12h,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [6:0]        sec,
  output logic [6:0]        min,
  output logic [5:0]        hour,
  output logic [2:0]        wday,
  output logic [5:0]        day,
  output logic [4:0]        month,
  output logic [7:0]        year
);
  // Named carry events.
  logic c_min, c_hour, c_day, c_mon, c_year;
  logic sec_last, min_last, hour_last, day_last, mon_last;
  logic w_sec, w_min, w_hour, w_wday, w_day, w_mon, w_year;
  logic [7:0] t_sec, t_min, t_hour, t_day, t_mon, t_year;
  logic [6:0] sec_nx, min_nx;
  logic [5:0] hour_nx, day_nx;
  logic [2:0] wday_nx;
  logic [4:0] mon_nx;
  logic [7:0] year_nx;

  assign w_sec  = wr_en && (wr_addr == A_SEC);
  assign w_min  = wr_en && (wr_addr == A_MIN);
  assign w_hour = wr_en && (wr_addr == A_HOUR);
  assign w_wday = wr_en && (wr_addr == A_WDAY);
  assign w_day  = wr_en && (wr_addr == A_DAY);
  assign w_mon  = wr_en && (wr_addr == A_MON);
  assign w_year = wr_en && (wr_addr == A_YEAR);

  assign sec_last  = (sec == 7'h59);
  assign min_last  = (min == 7'h59);
  assign hour_last = mode_12h ? (hour == 6'h31) : (hour == 6'h23);
  assign day_last  = (day == last_day(month, year));
  assign mon_last  = (month == 5'h12);

  assign c_min  = sec_adv && sec_last;
  assign c_hour = c_min && min_last;
  assign c_day  = c_hour && hour_last;
  assign c_mon  = c_day && day_last;
  assign c_year = c_mon && mon_last;

  always_comb begin
    t_sec  = bcd_step({1'b0, sec});
    t_min  = bcd_step({1'b0, min});
    t_hour = bcd_step({2'b00, hour});
    t_day  = bcd_step({2'b00, day});
    t_mon  = bcd_step({3'b000, month});
    t_year = bcd_step(year);
    sec_nx  = sec_last ? 7'h00 : t_sec[6:0];
    min_nx  = min_last ? 7'h00 : t_min[6:0];
    if (mode_12h) hour_nx = step_12h(hour);
    else          hour_nx = hour_last ? 6'h00 : t_hour[5:0];
    wday_nx = (wday >= 3'd6) ? 3'd0 : wday + 3'd1;
    day_nx  = day_last ? 6'h01 : t_day[5:0];
    mon_nx  = mon_last ? 5'h01 : t_mon[4:0];
    year_nx = (year == 8'h99) ? 8'h00 : t_year;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec   <= 7'h00;
      min   <= 7'h00;
      hour  <= 6'h00;
      wday  <= 3'd0;
      day   <= 6'h01;
      month <= 5'h01;
      year  <= 8'h00;
    end else begin
      if (w_sec)        sec   <= wr_data[6:0];
      else if (sec_adv) sec   <= sec_nx;
      if (w_min)        min   <= wr_data[6:0];
      else if (c_min)   min   <= min_nx;
      if (w_hour)       hour  <= wr_data[5:0];
      else if (c_hour)  hour  <= hour_nx;
      if (w_wday)       wday  <= wr_data[2:0];
      else if (c_day)   wday  <= wday_nx;
      if (w_day)        day   <= wr_data[5:0];
      else if (c_day)   day   <= day_nx;
      if (w_mon)        month <= wr_data[4:0];
      else if (c_mon)   month <= mon_nx;
      if (w_year)       year  <= wr_data;
      else if (c_year)  year  <= year_nx;
    end
  end

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_min && !w_sec) |=> (sec == 7'h00));
  // R5
  mon_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_year && !w_mon) |=> (month == 5'h01));
  // R4
  pm_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_12h && c_hour && hour[4:0] == 5'h11 && !w_hour) |=> (hour[5] != $past(hour[5])));
  // R7
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_adv && !wr_en) |=> $stable({sec, min, hour, wday, day, month, year}));
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [6:0]        min,
  input  logic [5:0]        hour,
  input  logic [5:0]        day,
  input  logic [2:0]        wday,
  output logic              alarm_flag
);
  localparam int NF = 4;

  logic [NF-1:0] en_q;
  logic [6:0]    a_min;
  logic [5:0]    a_hour;
  logic [5:0]    a_day;
  logic [2:0]    a_wday;
  logic [NF-1:0] eq;
  logic [NF-1:0] sel;
  logic          match_now, match_d, match_rise, flag_wr;

  assign sel = {wr_addr == A_AWDAY, wr_addr == A_ADAY, wr_addr == A_AHOUR, wr_addr == A_AMIN};
  assign eq  = {wday == a_wday, day == a_day, hour == a_hour, min == a_min};

  assign match_now  = (|en_q) && ((eq | ~en_q) == {NF{1'b1}});
  assign match_rise = match_now && !match_d;
  assign flag_wr    = wr_en && (wr_addr == A_FLAG);

  generate
    for (genvar i = 0; i < NF; i++) begin : g_en
      always_ff @(posedge clk) begin
        if (!rst_n)                en_q[i] <= 1'b0;
        else if (wr_en && sel[i])  en_q[i] <= wr_data[7];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_min  <= '0;
      a_hour <= '0;
      a_day  <= '0;
      a_wday <= '0;
      match_d    <= 1'b0;
      alarm_flag <= 1'b0;
    end else begin
      if (wr_en && sel[0]) a_min  <= wr_data[6:0];
      if (wr_en && sel[1]) a_hour <= wr_data[5:0];
      if (wr_en && sel[2]) a_day  <= wr_data[5:0];
      if (wr_en && sel[3]) a_wday <= wr_data[2:0];
      match_d    <= match_now;
      alarm_flag <= match_rise | (alarm_flag & (flag_wr ? wr_data[0] : 1'b1));
    end
  end

  // R9
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(match_rise));
  // R10
  no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_flag && !match_rise) |=> !alarm_flag);
  // R11
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !wr_data[0] && !match_rise) |=> !alarm_flag);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int SUB_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sub_tick,
  input  logic        stop,
  input  logic        mode_12h,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic [6:0]  sec_o,
  output logic [6:0]  min_o,
  output logic [5:0]  hour_o,
  output logic [2:0]  wday_o,
  output logic [5:0]  day_o,
  output logic [4:0]  month_o,
  output logic [7:0]  year_o,
  output logic        alarm_flag_o
);
  logic sec_adv;

  cal_tick_gate #(.SUB_DIV(SUB_DIV)) u_gate (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .stop(stop), .sec_adv(sec_adv)
  );

  cal_time_chain u_chain (
    .clk(clk), .rst_n(rst_n), .sec_adv(sec_adv), .mode_12h(mode_12h),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec(sec_o), .min(min_o), .hour(hour_o), .wday(wday_o),
    .day(day_o), .month(month_o), .year(year_o)
  );

  cal_alarm_unit u_alarm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .min(min_o), .hour(hour_o), .day(day_o), .wday(wday_o),
    .alarm_flag(alarm_flag_o)
  );
endmodule

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sub_tick = 1'b0, stop = 1'b0, mode_12h = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [6:0] sec_o, min_o;
  logic [5:0] hour_o, day_o;
  logic [2:0] wday_o;
  logic [4:0] month_o;
  logic [7:0] year_o;
  logic alarm_flag_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_calendar u_dut (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic pulse_tick();
    sub_tick = 1'b1; step(); sub_tick = 1'b0; step();
  endtask

  // Stop for a cycle so one sub-tick yields the next second.
  task automatic tick_one();
    stop = 1'b1; step(); stop = 1'b0;
    pulse_tick();
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(4'd2, h); wr(4'd1, m); wr(4'd0, s);
  endtask

  task automatic t_reset();
    chk("R1", "sec", sec_o, 0); chk("R1", "min", min_o, 0);
    chk("R1", "hour", hour_o, 0); chk("R1", "wday", wday_o, 0);
    chk("R1", "day", day_o, 6'h01); chk("R1", "month", month_o, 5'h01);
    chk("R1", "year", year_o, 0); chk("R1", "flag", alarm_flag_o, 0);
  endtask

  task automatic t_seconds();
    wr(4'd0, 8'h58);
    sub_tick = 1'b1; step(); sub_tick = 1'b0; step();
    chk("R2", "one sub-tick only", sec_o, 7'h58);
    pulse_tick();
    chk("R2", "sec after two sub-ticks", sec_o, 7'h59);
    pulse_tick(); pulse_tick();
    chk("R2", "sec wrap", sec_o, 7'h00);
    chk("R2", "min carry", min_o, 7'h01);
  endtask

  task automatic t_invalid();
    wr(4'd0, 8'h3C);
    tick_one();
    chk("R8", "non-BCD seconds", sec_o, 7'h40);
  endtask

  task automatic t_day24();
    mode_12h = 1'b0;
    wr(4'd3, 8'h06); wr(4'd4, 8'h15); wr(4'd5, 8'h03);
    set_time(8'h23, 8'h59, 8'h59);
    tick_one();
    chk("R3", "hour wrap", hour_o, 6'h00);
    chk("R3", "min wrap", min_o, 7'h00);
    chk("R3", "day carry", day_o, 6'h16);
    chk("R5", "weekday wrap", wday_o, 3'd0);
  endtask

  task automatic end_of_day(input logic [7:0] d, input logic [7:0] m, input logic [7:0] y);
    mode_12h = 1'b0;
    wr(4'd4, d); wr(4'd5, m); wr(4'd6, y);
    set_time(8'h23, 8'h59, 8'h59);
    tick_one();
  endtask

  task automatic t_calendar();
    end_of_day(8'h28, 8'h02, 8'h23);
    chk("R5", "Feb non-leap day", day_o, 6'h01); chk("R5", "Feb non-leap month", month_o, 5'h03);
    end_of_day(8'h28, 8'h02, 8'h24);
    chk("R5", "Feb leap day 29", day_o, 6'h29); chk("R5", "Feb leap month", month_o, 5'h02);
    end_of_day(8'h29, 8'h02, 8'h24);
    chk("R5", "leap Feb 29 -> Mar", month_o, 5'h03);
    end_of_day(8'h30, 8'h04, 8'h10);
    chk("R5", "Apr 30 -> day", day_o, 6'h01); chk("R5", "Apr 30 -> May", month_o, 5'h05);
    end_of_day(8'h30, 8'h05, 8'h10);
    chk("R5", "May 30 -> 31", day_o, 6'h31);
    end_of_day(8'h31, 8'h12, 8'h99);
    chk("R5", "year end month", month_o, 5'h01); chk("R5", "year wrap", year_o, 8'h00);
    chk("R5", "year end day", day_o, 6'h01);
  endtask

  task automatic t_12h();
    mode_12h = 1'b1;
    wr(4'd4, 8'h10);
    set_time(8'h11, 8'h59, 8'h59); tick_one();
    chk("R4", "11 AM -> 12 PM", hour_o, 6'h32);
    chk("R4", "no day carry at noon", day_o, 6'h10);
    set_time(8'h32, 8'h59, 8'h59); tick_one();
    chk("R4", "12 PM -> 1 PM", hour_o, 6'h21);
    set_time(8'h31, 8'h59, 8'h59); tick_one();
    chk("R4", "11 PM -> 12 AM", hour_o, 6'h12);
    chk("R4", "day carry at midnight", day_o, 6'h11);
    mode_12h = 1'b0;
  endtask

  task automatic t_stop();
    wr(4'd0, 8'h10);
    stop = 1'b1;
    repeat (4) pulse_tick();
    chk("R6", "frozen while stopped", sec_o, 7'h10);
    stop = 1'b0; step();
    pulse_tick();
    chk("R6", "first advance half second after release", sec_o, 7'h11);
  endtask

  task automatic t_write();
    logic [31:0] snap;
    stop = 1'b1; step(); stop = 1'b0;
    sub_tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'h20;
    step();
    sub_tick = 1'b0; wr_en = 1'b0; step();
    chk("R7", "write beats advance", sec_o, 7'h20);
    snap = {sec_o, min_o, hour_o, wday_o, day_o, month_o[2:0]};
    wr(4'd7, 8'h33); wr(4'd13, 8'h01); wr(4'd15, 8'h44);
    chk("R7", "unused addresses ignored", {sec_o, min_o, hour_o, wday_o, day_o, month_o[2:0]}, snap);
    chk("R7", "unused address flag", alarm_flag_o, 0);
  endtask

  task automatic t_alarm();
    mode_12h = 1'b0;
    set_time(8'h06, 8'h04, 8'h59);
    wr(4'd8, 8'h85);
    stop = 1'b1; step(); stop = 1'b0;
    sub_tick = 1'b1; step(); sub_tick = 1'b0;
    chk("R9", "minute reached", min_o, 7'h05);
    chk("R9", "flag not yet", alarm_flag_o, 0);
    step();
    chk("R9", "flag one cycle after match", alarm_flag_o, 1);
    wr(4'd12, 8'h01);
    chk("R11", "write 1 keeps flag", alarm_flag_o, 1);
    wr(4'd12, 8'hFE);
    chk("R11", "write 0 clears flag", alarm_flag_o, 0);
    pulse_tick(); pulse_tick();
    chk("R10", "lasting match no reset", alarm_flag_o, 0);
    wr(4'd1, 8'h04); wr(4'd1, 8'h05);
    wr(4'd12, 8'h00);
    chk("R11", "set beats clear", alarm_flag_o, 1);
    wr(4'd12, 8'h00);
    wr(4'd9, 8'h87);
    wr(4'd1, 8'h04); wr(4'd1, 8'h05); step();
    chk("R9", "hour mismatch blocks", alarm_flag_o, 0);
    wr(4'd2, 8'h07); step();
    chk("R9", "both fields match", alarm_flag_o, 1);
    wr(4'd12, 8'h00);
    wr(4'd8, 8'h05); wr(4'd9, 8'h07);
    wr(4'd1, 8'h04); wr(4'd1, 8'h05); step();
    chk("R9", "no field enabled", alarm_flag_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_seconds();
    t_invalid();
    t_day24();
    t_calendar();
    t_12h();
    t_stop();
    t_write();
    t_alarm();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule